// File: doc/BRIEF.md
# Transmit Channel Splitter and DAC Source Router

This block takes a stream of 16-bit host words that carry one or two interleaved complex transmit channels. It gathers one complete sample set, meaning every I and Q value needed for a single sample period. It then drives four DAC sample outputs. Each output comes from one of the four I/Q values of that set, or it is forced to zero.

A 32-bit configuration word controls the block. The low field gives the channel count. Four 4-bit fields, one per DAC, each hold an enable bit and a source index.

Input words arrive under valid/ready flow control. A sample strobe from the interpolation side moves a completed set to the outputs. If the strobe arrives before the set is complete, the outputs keep their values and a sticky underrun flag is raised.

Top module: `tx_dac_router`

## Requirements
- R1: After reset every DAC output is zero, `underrun` is 0 and `in_ready` is 1.
- R2: When `cfg_word[2:0]` equals 2, a sample set is four words, taken in the order channel 0 I, channel 0 Q, channel 1 I, channel 1 Q. Any other value means one channel, and the set is two words: channel 0 I, then channel 0 Q.
- R3: DAC k (k = 0..3) is configured by `cfg_word[4k+7:4k+4]`. Bit 3 of this field enables the DAC and bits 2:0 hold the source index. Index 0 selects channel 0 I, 1 selects channel 0 Q, 2 selects channel 1 I and 3 selects channel 1 Q. `cfg_word[3]` and `cfg_word[31:20]` must be zero.
- R4: A DAC whose enable bit is 0 outputs zero on the next update.
- R5: An enabled DAC whose source index is 4 to 7 outputs zero.
- R6: In one-channel mode, an enabled DAC whose source index is 2 or 3 outputs zero.
- R7: When the last word of a set is accepted, `in_ready` drops and stays low until a strobe consumes the set. All four outputs change together, in the cycle after the strobe edge that consumes a complete set, and at no other time.
- R8: A strobe that arrives while the set is incomplete leaves all outputs unchanged and sets `underrun`. The flag stays set until reset. Words already received for the partial set are kept, and a later strobe delivers the set once it is complete.
- R9: `dac_out[16k+15:16k]` carries DAC k.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 32 | Channel count and per-DAC enable/source fields |
| in_data | input | 16 | Host sample word |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Block accepts a word this cycle |
| samp_strobe | input | 1 | One pulse per DAC sample period |
| dac_out | output | 64 | Four DAC samples, DAC k at bits 16k+15:16k |
| underrun | output | 1 | Sticky: a strobe found the set incomplete |

## Verification
The bench builds the block with its default parameters: 16-bit samples and four DACs. With these values every source index from 0 to 7 can be driven through both channel counts. Identity, reversed, disabled and out-of-range routings are all reachable, and so are the full-set backpressure point and the underrun-then-recover sequence.

// File: rtl/tx_route_pkg.sv
package tx_route_pkg;
    localparam int SRC_COUNT = 4;
    localparam int FIELD_W   = 4;
    localparam int IDX_W     = 3;
    localparam logic [2:0] NCH_TWO = 3'd2;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] src;
    } dac_field_t;
endpackage

// File: rtl/tx_deinterleave.sv
module tx_deinterleave #(
    parameter int SAMP_W = 16
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   two_chan,
    input  logic [SAMP_W-1:0]                      in_data,
    input  logic                                   in_valid,
    input  logic                                   consume,
    output logic                                   in_ready,
    output logic                                   set_full,
    output logic [tx_route_pkg::SRC_COUNT*SAMP_W-1:0] slots
);
    import tx_route_pkg::*;
    localparam int CNT_W = $clog2(SRC_COUNT);

    typedef struct packed {
        logic [CNT_W-1:0]                cnt;
        logic                            full;
        logic [SRC_COUNT-1:0][SAMP_W-1:0] slot;
    } dein_state_t;

    dein_state_t st_d, st_q;
    logic [CNT_W-1:0] last_idx;
    logic             take;

    always_comb begin
        st_d     = st_q;
        last_idx = two_chan ? CNT_W'(SRC_COUNT - 1) : CNT_W'(1);
        take     = in_valid && !st_q.full;
        if (consume) st_d.full = 1'b0;
        if (take) begin
            st_d.slot[st_q.cnt] = in_data;
            if (st_q.cnt == last_idx) begin
                st_d.cnt  = '0;
                st_d.full = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_ready = !st_q.full;
    assign set_full = st_q.full;
    assign slots    = st_q.slot;

    p_backpressure_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && st_q.cnt == last_idx) |=> !in_ready);
    p_full_until_consume_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_full && !consume) |=> set_full);
endmodule

// File: rtl/tx_dac_select.sv
module tx_dac_select #(
    parameter int SAMP_W  = 16,
    parameter int NUM_DAC = 4
) (
    input  logic [NUM_DAC*tx_route_pkg::FIELD_W-1:0]   cfg_dac,
    input  logic                                       two_chan,
    input  logic [tx_route_pkg::SRC_COUNT*SAMP_W-1:0]  slots,
    output logic [NUM_DAC*SAMP_W-1:0]                  sel
);
    import tx_route_pkg::*;

    for (genvar k = 0; k < NUM_DAC; k++) begin : g_dac
        dac_field_t fld;
        logic       legal;
        assign fld = dac_field_t'(cfg_dac[k*FIELD_W +: FIELD_W]);
        always_comb begin
            legal = fld.en && (fld.src < IDX_W'(SRC_COUNT));
            if (!two_chan && fld.src[1]) legal = 1'b0;
            sel[k*SAMP_W +: SAMP_W] = legal ? slots[fld.src[1:0]*SAMP_W +: SAMP_W]
                                            : '0;
        end
    end
endmodule

// File: rtl/tx_dac_out_stage.sv
module tx_dac_out_stage #(
    parameter int SAMP_W  = 16,
    parameter int NUM_DAC = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        samp_strobe,
    input  logic                        set_full,
    input  logic [NUM_DAC*SAMP_W-1:0]   sel,
    output logic                        consume,
    output logic [NUM_DAC*SAMP_W-1:0]   dac_out,
    output logic                        underrun
);
    typedef struct packed {
        logic [NUM_DAC*SAMP_W-1:0] dac;
        logic                      urun;
    } out_state_t;

    out_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        consume = samp_strobe && set_full;
        if (consume)                  st_d.dac  = sel;
        if (samp_strobe && !set_full) st_d.urun = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dac_out  = st_q.dac;
    assign underrun = st_q.urun;

    p_hold_without_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_strobe |=> $stable(dac_out));
    p_underrun_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_strobe && !set_full) |=> ($stable(dac_out) && underrun));
    p_underrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);
endmodule

// File: rtl/tx_dac_router.sv
module tx_dac_router #(
    parameter int SAMP_W  = 16,
    parameter int NUM_DAC = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [31:0]                 cfg_word,
    input  logic [SAMP_W-1:0]           in_data,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic                        samp_strobe,
    output logic [NUM_DAC*SAMP_W-1:0]   dac_out,
    output logic                        underrun
);
    import tx_route_pkg::*;
    localparam int CFG_USED = FIELD_W + NUM_DAC*FIELD_W;

    logic                         two_chan;
    logic                         set_full;
    logic                         consume;
    logic [SRC_COUNT*SAMP_W-1:0]  slots;
    logic [NUM_DAC*SAMP_W-1:0]    sel;

    assign two_chan = (cfg_word[2:0] == NCH_TWO);

    tx_deinterleave #(.SAMP_W(SAMP_W)) u_dein (
        .clk(clk), .rst_n(rst_n), .two_chan(two_chan),
        .in_data(in_data), .in_valid(in_valid), .consume(consume),
        .in_ready(in_ready), .set_full(set_full), .slots(slots)
    );

    tx_dac_select #(.SAMP_W(SAMP_W), .NUM_DAC(NUM_DAC)) u_sel (
        .cfg_dac(cfg_word[CFG_USED-1:FIELD_W]), .two_chan(two_chan),
        .slots(slots), .sel(sel)
    );

    tx_dac_out_stage #(.SAMP_W(SAMP_W), .NUM_DAC(NUM_DAC)) u_out (
        .clk(clk), .rst_n(rst_n), .samp_strobe(samp_strobe),
        .set_full(set_full), .sel(sel), .consume(consume),
        .dac_out(dac_out), .underrun(underrun)
    );

    p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_word[3] == 1'b0) && (cfg_word[31:CFG_USED] == '0));
    p_disabled_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_strobe && set_full && !cfg_word[FIELD_W+3]) |=> (dac_out[SAMP_W-1:0] == '0));
endmodule

// File: tb/tx_dac_router_tb.sv
module tx_dac_router_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;
    localparam int N = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [31:0]     cfg_word = '0;
    logic [W-1:0]    in_data = '0;
    logic            in_valid = 1'b0;
    logic            samp_strobe = 1'b0;
    logic            in_ready;
    logic [N*W-1:0]  dac_out;
    logic            underrun;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_dac_router #(.SAMP_W(W), .NUM_DAC(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .in_data(in_data),
        .in_valid(in_valid), .in_ready(in_ready), .samp_strobe(samp_strobe),
        .dac_out(dac_out), .underrun(underrun)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_word(input logic [W-1:0] d);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pulse_strobe();
        @(negedge clk);
        samp_strobe = 1'b1;
        @(negedge clk);
        samp_strobe = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 dac_out", dac_out, 64'h0);
        check("R1 underrun", {63'h0, underrun}, 64'h0);
        check("R1 in_ready", {63'h0, in_ready}, 64'h1);
    endtask

    task automatic t_two_chan_identity();
        cfg_word = 32'h000B_A982;
        push_word(16'h1111); push_word(16'h2222);
        push_word(16'h3333); push_word(16'h4444);
        check("R7 ready low when set full", {63'h0, in_ready}, 64'h0);
        check("R7 no update before strobe", dac_out, 64'h0);
        pulse_strobe();
        check("R2 R3 R9 identity routing", dac_out, 64'h4444_3333_2222_1111);
        check("R7 ready after consume", {63'h0, in_ready}, 64'h1);
    endtask

    task automatic t_reversed();
        cfg_word = 32'h0008_9AB2;
        push_word(16'hA001); push_word(16'hA002);
        push_word(16'hA003); push_word(16'hA004);
        pulse_strobe();
        check("R3 reversed routing", dac_out, 64'hA001_A002_A003_A004);
    endtask

    task automatic t_disabled();
        cfg_word = 32'h000B_A182;
        push_word(16'hD001); push_word(16'hD002);
        push_word(16'hD003); push_word(16'hD004);
        pulse_strobe();
        check("R4 DAC1 disabled", dac_out, 64'hD004_D003_0000_D001);
    endtask

    task automatic t_bad_index();
        cfg_word = 32'h000B_AFC2;
        push_word(16'hE001); push_word(16'hE002);
        push_word(16'hE003); push_word(16'hE004);
        pulse_strobe();
        check("R5 index above 3", dac_out, 64'hE004_E003_0000_0000);
    endtask

    task automatic t_one_chan();
        cfg_word = 32'h000B_A981;
        push_word(16'hB001); push_word(16'hB002);
        check("R2 one-channel set is two words", {63'h0, in_ready}, 64'h0);
        pulse_strobe();
        check("R6 channel 1 index in one-channel mode", dac_out, 64'h0000_0000_B002_B001);
    endtask

    task automatic t_underrun();
        push_word(16'hC001);
        pulse_strobe();
        check("R8 outputs held on underrun", dac_out, 64'h0000_0000_B002_B001);
        check("R8 underrun set", {63'h0, underrun}, 64'h1);
        push_word(16'hC002);
        pulse_strobe();
        check("R8 partial set kept then delivered", dac_out, 64'h0000_0000_C002_C001);
        check("R8 underrun sticky", {63'h0, underrun}, 64'h1);
        do_reset();
        check("R1 underrun cleared by reset", {63'h0, underrun}, 64'h0);
    endtask

    initial begin
        t_reset();
        t_two_chan_identity();
        t_reversed();
        t_disabled();
        t_bad_index();
        t_one_chan();
        t_underrun();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD*100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule